// File: doc/BRIEF.md
# Next-PC Selection Unit

This block owns the program counter of a small 16-bit processor and decides, every cycle, where the next instruction is fetched from. An instruction is one 16-bit word and the PC counts in words. Each cycle the unit picks one of three next values: the sequential address (PC + 1), a PC-relative branch target, or an absolute target supplied from a register. The decode stage raises a branch or jump strobe along with the operands, and the flag logic supplies the zero, negative and overflow flags of the last compare or ALU result.

A relative branch is qualified by a 3-bit condition code evaluated on the flags as a signed comparison. Code 111 branches unconditionally and code 110 is reserved and never branches. An absolute jump always takes effect and copies the register operand into the PC. The target and the taken indication are combinational in the cycle the instruction is presented, and the PC register loads the chosen value on the next rising clock edge. While the valid strobe is low the PC holds its value.

Top module: `npc_unit`

## Requirements
- R1: After the asynchronous active-low reset, `pc_o` is 0.
- R2: With `valid_i` high and nothing taken, `taken_o` is 0, `next_pc_o` equals `pc_o + 1` modulo 2^16, and `pc_o` takes that value at the next rising edge.
- R3: With `valid_i` low, `taken_o` is 0, `next_pc_o` equals `pc_o`, and `pc_o` stays unchanged at the next edge, whatever the other inputs are.
- R4: With `valid_i` and `jump_i` high, `taken_o` is 1 and `next_pc_o` equals `jmp_tgt_i`. This applies whatever `branch_i`, `cond_i` and the flags are.
- R5: A taken relative branch gives `next_pc_o = pc_o + 1 + sign_extend(offset_i)` modulo 2^16, with `offset_i` taken as an 8-bit two's complement count of words (0x7F = +127, 0x80 = -128).
- R6: Code 000 (`cond_i` = 3'b000) branches when Z = 1. Code 001 branches when Z = 0.
- R7: Code 010 branches when Z = 0 and N = V (signed greater). Code 011 branches when N = V (signed greater or equal).
- R8: Code 100 branches when N != V (signed less). Code 101 branches when Z = 1 or N != V (signed less or equal).
- R9: Code 111 always branches and code 110 never branches, whatever the flags are.
- R10: `taken_o` and `next_pc_o` reflect the inputs in the same cycle, with no register between them and the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An instruction is presented this cycle |
| branch_i | input | 1 | The instruction is a conditional relative branch |
| jump_i | input | 1 | The instruction is an absolute register jump |
| cond_i | input | 3 | Branch condition code |
| offset_i | input | 8 | Signed relative offset in words |
| jmp_tgt_i | input | 16 | Absolute target read from a register |
| flag_z_i | input | 1 | Zero flag |
| flag_n_i | input | 1 | Negative flag |
| flag_v_i | input | 1 | Signed overflow flag |
| pc_o | output | 16 | Current program counter |
| next_pc_o | output | 16 | Program counter for the next cycle |
| taken_o | output | 1 | A branch or jump redirects the PC this cycle |

## Verification
`taken_o` and `next_pc_o` depend only on the current inputs and `pc_o`, so they are due in the same cycle as the stimulus. `pc_o` is due one rising edge later. The bench applies each stimulus on the falling edge and samples the combinational outputs shortly afterwards, before the next rising edge. It then advances its reference PC at that rising edge, so the `pc_o` sampled on the following falling edge is compared against the value the model committed. Offsets at both extremes and targets near the address wrap are included among the mixed stimulus.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [2:0] {
    CC_EQ  = 3'b000,
    CC_NE  = 3'b001,
    CC_GT  = 3'b010,
    CC_GE  = 3'b011,
    CC_LT  = 3'b100,
    CC_LE  = 3'b101,
    CC_RSV = 3'b110,
    CC_ALW = 3'b111
  } cc_e;

  typedef struct packed {
    logic z;
    logic n;
    logic v;
  } flags_t;
endpackage

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
  import npc_pkg::*;
(
  input  cc_e    cc_i,
  input  flags_t flags_i,
  output logic   hit_o
);
  logic lt;
  assign lt = flags_i.n ^ flags_i.v;

  always_comb begin
    unique case (cc_i)
      CC_EQ:   hit_o = flags_i.z;
      CC_NE:   hit_o = ~flags_i.z;
      CC_GT:   hit_o = ~flags_i.z & ~lt;
      CC_GE:   hit_o = ~lt;
      CC_LT:   hit_o = lt;
      CC_LE:   hit_o = flags_i.z | lt;
      CC_ALW:  hit_o = 1'b1;
      default: hit_o = 1'b0; // reserved code never branches
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target #(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned OFF_W = 8
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OFF_W-1:0] offset_i,
  output logic [PC_W-1:0]  seq_o,
  output logic [PC_W-1:0]  rel_o
);
  localparam int unsigned EXT_W = PC_W - OFF_W;

  logic [PC_W-1:0] off_ext;

  generate
    if (EXT_W > 0) begin : g_sext
      assign off_ext = {{EXT_W{offset_i[OFF_W-1]}}, offset_i};
    end else begin : g_trunc
      assign off_ext = offset_i[PC_W-1:0];
    end
  endgenerate

  assign seq_o = pc_i + PC_W'(1);
  assign rel_o = seq_o + off_ext;
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned OFF_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             branch_i,
  input  logic             jump_i,
  input  logic [2:0]       cond_i,
  input  logic [OFF_W-1:0] offset_i,
  input  logic [PC_W-1:0]  jmp_tgt_i,
  input  logic             flag_z_i,
  input  logic             flag_n_i,
  input  logic             flag_v_i,
  output logic [PC_W-1:0]  pc_o,
  output logic [PC_W-1:0]  next_pc_o,
  output logic             taken_o
);
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] rel_pc;
  logic            cond_hit;
  logic            br_take;
  logic            jmp_take;
  flags_t          flags;

  assign flags = '{z: flag_z_i, n: flag_n_i, v: flag_v_i};

  npc_cond_eval i_cond (
    .cc_i    (cc_e'(cond_i)),
    .flags_i (flags),
    .hit_o   (cond_hit)
  );

  npc_target #(.PC_W(PC_W), .OFF_W(OFF_W)) i_tgt (
    .pc_i     (pc_q),
    .offset_i (offset_i),
    .seq_o    (seq_pc),
    .rel_o    (rel_pc)
  );

  // jump wins over branch
  assign jmp_take = valid_i & jump_i;
  assign br_take  = valid_i & ~jump_i & branch_i & cond_hit;

  always_comb begin
    if (!valid_i)      next_pc_o = pc_q;
    else if (jmp_take) next_pc_o = jmp_tgt_i;
    else if (br_take)  next_pc_o = rel_pc;
    else               next_pc_o = seq_pc;
  end

  assign taken_o = jmp_take | br_take;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= next_pc_o;
  end

  assign pc_o = pc_q;

  // R2
  seq_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !taken_o) |=> pc_o == $past(pc_o) + PC_W'(1));

  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(pc_o));

  // R3
  idle_no_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !taken_o);

  // R4
  jump_tgt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && jump_i) |=> pc_o == $past(jmp_tgt_i));

  // R9
  rsv_never_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && branch_i && !jump_i && cond_i == 3'b110) |-> !taken_o);

  // R9
  always_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && branch_i && cond_i == 3'b111) |-> taken_o);

  // R7
  ge_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && branch_i && !jump_i && cond_i == 3'b011) |-> taken_o == (flag_n_i == flag_v_i));
endmodule

// File: tb/test_npc_unit.sv
module test_npc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        branch = 1'b0;
  logic        jump = 1'b0;
  logic [2:0]  cond = '0;
  logic [7:0]  offset = '0;
  logic [15:0] tgt = '0;
  logic        fz = 1'b0, fn = 1'b0, fv = 1'b0;
  logic [15:0] pc, next_pc;
  logic        taken;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  npc_unit i_npc_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .branch_i(branch),
    .jump_i(jump), .cond_i(cond), .offset_i(offset), .jmp_tgt_i(tgt),
    .flag_z_i(fz), .flag_n_i(fn), .flag_v_i(fv),
    .pc_o(pc), .next_pc_o(next_pc), .taken_o(taken)
  );

  function automatic bit ref_cond(input int c, input bit z, input bit n, input bit v);
    bit lt = (n != v);
    case (c)
      0: return z;
      1: return !z;
      2: return !z && !lt;
      3: return !lt;
      4: return lt;
      5: return z || lt;
      6: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic string cond_tag(input int c);
    case (c)
      0, 1: return "R6";
      2, 3: return "R7";
      4, 5: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int model_pc = 0;

  task automatic step(input bit v, input bit b, input bit j, input int c,
                      input int off, input int t, input bit z, input bit n, input bit ov);
    int exp_next;
    bit exp_take;
    string tag;
    int soff;
    @(negedge clk);
    valid = v; branch = b; jump = j; cond = 3'(c); offset = 8'(off);
    tgt = 16'(t); fz = z; fn = n; fv = ov;
    #2;
    soff = (off & 8'h80) ? (off & 8'hFF) - 256 : (off & 8'hFF);
    if (!v) begin
      exp_take = 1'b0; exp_next = model_pc; tag = "R3";
    end else if (j) begin
      exp_take = 1'b1; exp_next = t & 16'hFFFF; tag = "R4";
    end else if (b && ref_cond(c, z, n, ov)) begin
      exp_take = 1'b1; exp_next = (model_pc + 1 + soff) & 16'hFFFF; tag = "R5";
    end else begin
      exp_take = 1'b0; exp_next = (model_pc + 1) & 16'hFFFF;
      tag = b ? cond_tag(c) : "R2";
    end
    check("R2 pc", int'(pc), model_pc);
    // R10: combinational outputs due in the stimulus cycle
    check(b && v && !j ? {cond_tag(c), " R10 taken"} : {tag, " R10 taken"},
          int'(taken), int'(exp_take));
    check({tag, " next_pc"}, int'(next_pc), exp_next);
    @(posedge clk);
    model_pc = exp_next;
  endtask

  initial begin
    #25;
    check("R1 reset pc", int'(pc), 0);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 pc after release", int'(pc), 0);
    // sequential
    for (int k = 0; k < 4; k++) step(1, 0, 0, 0, 0, 0, 0, 0, 0);
    // idle with noise on other inputs
    step(0, 1, 1, 7, 8'h40, 16'h1234, 1, 1, 1);
    step(0, 1, 0, 7, 8'h10, 0, 0, 0, 0);
    // R9 always and reserved
    step(1, 1, 0, 7, 8'h7F, 0, 0, 0, 0);
    step(1, 1, 0, 6, 8'h20, 0, 1, 1, 0);
    step(1, 1, 0, 6, 8'h20, 0, 0, 0, 0);
    // R5 negative extreme
    step(1, 1, 0, 7, 8'h80, 0, 0, 0, 0);
    // R4 jump wins over branch, near wrap
    step(1, 1, 1, 6, 8'h05, 16'hFFFE, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0, 0);
    // R5 backward across zero
    step(1, 1, 0, 7, 8'hFC, 0, 0, 0, 0);
    // every code against every flag combination
    for (int c = 0; c < 8; c++)
      for (int f = 0; f < 8; f++)
        step(1, 1, 0, c, 8'h03 + f, 0, f[2], f[1], f[0]);
    // mixed
    for (int k = 0; k < 400; k++) begin
      int m = $urandom_range(0, 9);
      int offs = (k % 5 == 0) ? 8'h80 : (k % 5 == 1) ? 8'h7F : $urandom_range(0, 255);
      step(m != 0, m >= 3, m == 9, $urandom_range(0, 7), offs,
           $urandom_range(0, 65535), $urandom_range(0, 1), $urandom_range(0, 1),
           $urandom_range(0, 1));
    end
    @(negedge clk);
    check("R2 final pc", int'(pc), model_pc);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule